// File: doc/BRIEF.md
# Partial Bus Invert Coder

This block reduces switching on an n-bit parallel bus that carries one extra invert wire. For each new word the encoder measures how many wires would toggle if the word were sent unchanged. It counts only the selected lines and the invert wire itself. When more than half of those wires would toggle, the encoder complements the selected lines and drives the invert wire high. Lines outside the selection are always sent unchanged. The bus value and the invert wire are registered. They change only on a valid strobe.

A combinational decoder sits on the wire side. It complements the selected lines whenever the invert wire is high, so it recovers the original word. The selection mask is a static input. The sender and the receiver must see the same mask. With an all-ones mask the block behaves as conventional whole-word bus invert coding. With an empty mask the data always passes through unchanged.

Top module: `pbi_coder`

## Requirements
- R1: After reset, `bus_lines` and `bus_inv` are all zeros, and `dec_data` therefore reads zero.
- R2: While `in_valid` is low, `bus_lines` and `bus_inv` keep their values, whatever `in_data` does.
- R3: On a strobe, let H be the number of selected lines (mask bit 1) on which the current `bus_lines` differs from `in_data`, plus 1 if `bus_inv` is currently 1. Let m be the number of ones in `sel_mask`. The new `bus_inv` is 1 exactly when 2·H > m+1.
- R4: When 2·H equals m+1 exactly (a tie), the new `bus_inv` is 0.
- R5: After a strobe, `bus_lines` equals `in_data` with the selected lines complemented when the new `bus_inv` is 1. Unselected lines always equal `in_data`.
- R6: `dec_data` equals `bus_lines` with the selected lines complemented when `bus_inv` is 1. After a strobe it equals the strobed word while the mask is unchanged.
- R7: On each strobe, the number of toggles across the selected lines and the invert wire is at most floor((m+1)/2).
- R8: With an all-zero mask, `bus_lines` after every strobe equals the strobed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: encode and register `in_data` |
| in_data | input | W | Word to send |
| sel_mask | input | W | 1 marks a line eligible for inversion |
| bus_lines | output | W | Registered coded data lines |
| bus_inv | output | 1 | Registered invert wire |
| dec_data | output | W | Decoded word seen by the receiver |

## Verification
The encoder adds one register stage. A word strobed at a rising edge shows up on `bus_lines` and `bus_inv` at that edge. Because the decoder is combinational, `dec_data` follows in the same cycle. The bench drives inputs at the falling edge and samples every result at the next falling edge, half a cycle after the capturing edge. At that point it compares against a reference that it builds from the previous wire state it has tracked. For hold checks, the bench changes `in_data` without a strobe and samples one full cycle later, to confirm the wires did not move.

// File: rtl/pbi_pkg.sv
package pbi_pkg;
   // width of a count that can hold 2*(W+1)
   function automatic int cnt_width(input int w);
      return $clog2(w + 2) + 1;
   endfunction
endpackage

// File: rtl/pbi_popcount.sv
module pbi_popcount #(
   parameter int W  = 16,
   parameter int CW = 6
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] count
);
   logic [CW-1:0] acc [0:W];
   assign acc[0] = '0;
   for (genvar i = 0; i < W; i++) begin : g_sum
      assign acc[i+1] = acc[i] + CW'(vec[i]);
   end
   assign count = acc[W];
endmodule

// File: rtl/pbi_decide.sv
module pbi_decide #(
   parameter int W = 16
) (
   input  logic [W-1:0] cur_bus,
   input  logic         cur_inv,
   input  logic [W-1:0] next_data,
   input  logic [W-1:0] mask,
   output logic         do_invert
);
   import pbi_pkg::*;
   localparam int CW = cnt_width(W);

   logic [CW-1:0] diff_cnt;
   logic [CW-1:0] sel_cnt;
   logic [CW-1:0] cost;

   pbi_popcount #(.W(W), .CW(CW)) u_diff (
      .vec   ((cur_bus ^ next_data) & mask),
      .count (diff_cnt)
   );
   pbi_popcount #(.W(W), .CW(CW)) u_sel (
      .vec   (mask),
      .count (sel_cnt)
   );

   assign cost      = diff_cnt + CW'(cur_inv);
   // strict compare: a tie keeps the invert wire low
   assign do_invert = (cost << 1) > (sel_cnt + CW'(1));
endmodule

// File: rtl/pbi_encoder.sv
module pbi_encoder #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   input  logic [W-1:0] sel_mask,
   output logic [W-1:0] bus_q,
   output logic         inv_q
);
   logic do_inv;

   pbi_decide #(.W(W)) u_decide (
      .cur_bus   (bus_q),
      .cur_inv   (inv_q),
      .next_data (in_data),
      .mask      (sel_mask),
      .do_invert (do_inv)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_q <= '0;
         inv_q <= 1'b0;
      end else if (in_valid) begin
         bus_q <= in_data ^ (sel_mask & {W{do_inv}});
         inv_q <= do_inv;
      end
   end

   // R2
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(bus_q) && $stable(inv_q)));

   // R5
   selected_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((bus_q ^ $past(in_data)) == ($past(sel_mask) & {W{inv_q}})));

   // R7
   toggle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (2 * ($countones((bus_q ^ $past(bus_q)) & $past(sel_mask))
                         + $countones(inv_q ^ $past(inv_q)))
                    <= $countones($past(sel_mask)) + 1));

   // R8
   empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel_mask == '0) |=> (bus_q == $past(in_data)));
endmodule

// File: rtl/pbi_decoder.sv
module pbi_decoder #(
   parameter int W = 16
) (
   input  logic [W-1:0] bus_in,
   input  logic         inv_in,
   input  logic [W-1:0] sel_mask,
   output logic [W-1:0] data_out
);
   for (genvar i = 0; i < W; i++) begin : g_line
      assign data_out[i] = bus_in[i] ^ (sel_mask[i] & inv_in);
   end
endmodule

// File: rtl/pbi_coder.sv
module pbi_coder #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   input  logic [W-1:0] sel_mask,
   output logic [W-1:0] bus_lines,
   output logic         bus_inv,
   output logic [W-1:0] dec_data
);
   if (W < 1) begin : g_bad_width
      $error("pbi_coder: W must be at least 1");
   end

   pbi_encoder #(.W(W)) u_enc (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .sel_mask (sel_mask),
      .bus_q    (bus_lines),
      .inv_q    (bus_inv)
   );

   pbi_decoder #(.W(W)) u_dec (
      .bus_in   (bus_lines),
      .inv_in   (bus_inv),
      .sel_mask (sel_mask),
      .data_out (dec_data)
   );

   // R6
   round_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (!$stable(sel_mask) || dec_data == $past(in_data)));
endmodule

// File: tb/pbi_coder_bench.sv
module pbi_coder_bench;
   localparam int W = 16;
   localparam time PERIOD = 10ns;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic [W-1:0] sel_mask = '1;
   logic [W-1:0] bus_lines;
   logic         bus_inv;
   logic [W-1:0] dec_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [W-1:0] m_bus = '0;
   logic         m_inv = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   pbi_coder #(.W(W)) u_pbi_coder (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
      .sel_mask (sel_mask), .bus_lines (bus_lines), .bus_inv (bus_inv),
      .dec_data (dec_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one strobe, checked against the reference on all results
   task automatic send(input logic [W-1:0] d, input logic [W-1:0] mk);
      int h, m, tog;
      logic ni;
      logic [W-1:0] eb;
      @(negedge clk);
      in_data = d; sel_mask = mk; in_valid = 1'b1;
      h  = $countones((m_bus ^ d) & mk) + int'(m_inv);
      m  = $countones(mk);
      ni = (2 * h) > (m + 1);
      eb = d ^ (mk & {W{ni}});
      @(negedge clk);
      in_valid = 1'b0;
      check("R3 invert decision", 32'(bus_inv), 32'(ni));
      check("R5 coded lines", 32'(bus_lines), 32'(eb));
      check("R6 decoded word", 32'(dec_data), 32'(d));
      tog = $countones((bus_lines ^ m_bus) & mk) + int'(bus_inv ^ m_inv);
      check("R7 toggle bound", 32'(2 * tog <= m + 1), 32'd1);
      m_bus = bus_lines; m_inv = bus_inv;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 lines after reset", 32'(bus_lines), 32'd0);
      check("R1 invert after reset", 32'(bus_inv), 32'd0);
      check("R1 decoded after reset", 32'(dec_data), 32'd0);
      rst_n = 1'b1;
      m_bus = '0; m_inv = 1'b0;
   endtask

   task automatic t_full_mask();
      send(16'hFFFF, 16'hFFFF);
      check("R3 full mask inverts", 32'(bus_lines), 32'h0000);
      send(16'h00FF, 16'hFFFF); // H = 8 + 1 = 9, 18 > 17
      check("R3 invert wire counted", 32'(bus_inv), 32'd1);
      check("R5 full mask value", 32'(bus_lines), 32'hFF00);
      send(16'h0F00, 16'hFFFF);
   endtask

   task automatic t_hold();
      logic [W-1:0] b0;
      logic         i0;
      b0 = bus_lines; i0 = bus_inv;
      @(negedge clk); in_data = ~in_data;
      @(negedge clk); in_data = 16'h1234;
      @(negedge clk);
      check("R2 lines held", 32'(bus_lines), 32'(b0));
      check("R2 invert held", 32'(bus_inv), 32'(i0));
   endtask

   task automatic t_tie();
      t_reset();
      send(16'h0003, 16'h0007); // H = 2, m+1 = 4: tie
      check("R4 tie keeps invert low", 32'(bus_inv), 32'd0);
      check("R4 tie lines", 32'(bus_lines), 32'h0003);
      t_reset();
      send(16'h8007, 16'h0007); // H = 3 > 2
      check("R5 unselected untouched", 32'(bus_lines), 32'h8000);
      check("R3 above threshold", 32'(bus_inv), 32'd1);
   endtask

   task automatic t_empty_mask();
      send(16'hA5A5, 16'h0000);
      check("R8 empty mask passes", 32'(bus_lines), 32'hA5A5);
      send(16'h5A5A, 16'h0000);
      check("R8 empty mask passes", 32'(bus_lines), 32'h5A5A);
   endtask

   task automatic t_sweep();
      logic [W-1:0] lf;
      lf = 16'hACE1;
      for (int k = 0; k < 200; k++) begin
         lf = {lf[W-2:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         send(lf, (k < 100) ? 16'hF0F3 : 16'hFFFF);
      end
   endtask

   initial begin
      #(PERIOD * 100000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_full_mask();
      t_hold();
      t_tie();
      t_empty_mask();
      t_sweep();
      t_hold();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule